// File: doc/BRIEF.md
# Register-Buffered Operand Stack

This block is the operand stack of a zero-operand processor core. The element a program treats as the top of the stack is held in a dedicated register. Every element below it is kept in a small stack RAM that is addressed from an up/down element counter. An integer ALU takes its two operands from the top register and the topmost RAM cell, and writes its result back into the register. As a result, a two-operand operation pops one RAM cell and never pushes.

A sequencer issues one operation per cycle. It places an operation code on `op_i` and an operand on `din_i`, then pulses `step_i`. The new top, the element below it and a zero indication appear after the clock edge. Literal loads and memory fetches enter through the push-literal operation. Stores and conditional branches read the current top from `tos_o` and then issue a drop, which reloads the register from the RAM. An operation that would exceed the capacity, or that needs more elements than are present, leaves the stack untouched. Instead it sets a sticky exception flag, which the sequencer clears with `ack_i`.

Top module: `opstack_unit`

## Requirements
- R1: After reset, `tos_o` and `nos_o` are 0, `zero_o` is 1, `ovf_o` and `unf_o` are 0, and the stack holds no elements.
- R2: Code 1 (push literal) makes `din_i` the new top. The previous top becomes the second element.
- R3: Code 2 (drop) removes the top. The second element becomes the top, and the third becomes the second. `nos_o` reads 0 whenever fewer than two elements are held, and `tos_o` reads 0 when none are held.
- R4: Code 3 (dup) copies the top into the second position. Code 4 (swap) exchanges the top two elements. Code 5 (over) pushes a copy of the second element, so the sequence x y becomes x y x.
- R5: Code 6 (add) yields second+top. Code 7 (subtract) yields second−top. Both wrap modulo 2^DATA_W, and both replace the top two elements with the single result.
- R6: Codes 8, 9 and 10 (bitwise AND, OR, XOR) replace the top two elements with the bitwise result.
- R7: Code 11 (zero test) replaces the top with all ones if it was 0, and with 0 otherwise. The element count is unchanged.
- R8: After every clock edge, `zero_o` is 1 exactly when `tos_o` is 0.
- R9: The stack holds at most DEPTH+1 elements. Codes 1, 3 and 5 are growing operations. A growing operation on a full stack changes nothing and sets `ovf_o`, which stays set.
- R10: Codes 2, 3 and 11 need one element, and codes 4 to 10 need two. An operation issued with fewer elements than it needs changes nothing and sets `unf_o`, which stays set. This check takes priority over the capacity check.
- R11: `ack_i` clears both flags at the next edge. A fault raised in the same cycle as `ack_i` leaves its flag set.
- R12: Codes 0 and 12 to 15 have no effect. Any code presented without `step_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Execute `op_i` this cycle |
| op_i | input | 4 | Operation code |
| din_i | input | DATA_W | Operand for the push-literal operation |
| ack_i | input | 1 | Clear the exception flags |
| tos_o | output | DATA_W | Top element (register) |
| nos_o | output | DATA_W | Second element (top RAM cell) |
| zero_o | output | 1 | Top element equals zero |
| ovf_o | output | 1 | Sticky capacity-exceeded flag |
| unf_o | output | 1 | Sticky not-enough-elements flag |

## Verification
Two events can meet in one cycle: an exception flag being raised by a faulting step, and that same flag being cleared by `ack_i`. The bench provokes this by issuing a push literal on a full stack while asserting `ack_i`, and then a drop on an empty stack while asserting `ack_i`. The expected result is that the flag is still set afterwards. A following acknowledge with no step must then clear it. Around this, a sweep runs every code at every fill level of a small configuration. After each step the bench drains the stack to confirm its contents, and the ALU codes are swept over a grid of operand pairs.

// File: rtl/opstack_pkg.sv
package opstack_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_LIT  = 4'd1,
    OP_DROP = 4'd2,
    OP_DUP  = 4'd3,
    OP_SWAP = 4'd4,
    OP_OVER = 4'd5,
    OP_ADD  = 4'd6,
    OP_SUB  = 4'd7,
    OP_AND  = 4'd8,
    OP_OR   = 4'd9,
    OP_XOR  = 4'd10,
    OP_ZEQ  = 4'd11
  } op_e;

  // operation is defined at all
  function automatic logic op_live(input logic [3:0] op);
    return (op >= 4'd1) && (op <= 4'd11);
  endfunction

  // operation adds one element
  function automatic logic op_grow(input logic [3:0] op);
    return (op == OP_LIT) || (op == OP_DUP) || (op == OP_OVER);
  endfunction

  // two-operand ALU operation
  function automatic logic op_binary(input logic [3:0] op);
    return (op >= 4'd6) && (op <= 4'd10);
  endfunction

  // operation removes one element
  function automatic logic op_shrink(input logic [3:0] op);
    return (op == OP_DROP) || op_binary(op);
  endfunction

  // minimum number of elements the operation consumes
  function automatic logic [1:0] op_need(input logic [3:0] op);
    logic [1:0] n;
    case (op)
      OP_DROP, OP_DUP, OP_ZEQ: n = 2'd1;
      OP_SWAP, OP_OVER:        n = 2'd2;
      default:                 n = op_binary(op) ? 2'd2 : 2'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/opstack_ram.sv
module opstack_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/opstack_ptr.sv
module opstack_ptr
  import opstack_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  logic [3:0]    op_i,
  output logic [CW-1:0] cnt_o,
  output logic          commit_o,
  output logic          ovf_evt_o,
  output logic          unf_evt_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o
);

  localparam logic [CW-1:0] CAP = CW'(DEPTH + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_m1, cnt_m2;
  logic          live, short, full, grow, shrink;

  assign cnt_m1 = cnt_q - CW'(1);
  assign cnt_m2 = cnt_q - CW'(2);

  assign live   = step_i && op_live(op_i);
  assign grow   = op_grow(op_i);
  assign shrink = op_shrink(op_i);
  assign short  = cnt_q < CW'(op_need(op_i));
  assign full   = grow && (cnt_q == CAP);

  assign unf_evt_o = live && short;
  assign ovf_evt_o = live && !short && full;
  assign commit_o  = live && !short && !full;

  // the register absorbs the first element, so an empty stack never writes RAM
  assign wr_en_o   = commit_o && ((grow && (cnt_q != '0)) || (op_i == OP_SWAP));
  assign wr_addr_o = (op_i == OP_SWAP) ? AW'(cnt_m2) : AW'(cnt_m1);
  assign rd_addr_o = AW'(cnt_m2);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (commit_o) begin
      if (grow)        cnt_q <= cnt_q + CW'(1);
      else if (shrink) cnt_q <= cnt_m1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CAP);  // R9

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(cnt_q));  // R12

  AST_UNF_KEEPS_CNT: assert property (@(posedge clk) disable iff (rst)
    unf_evt_o |=> $stable(cnt_q));  // R10

endmodule

// File: rtl/opstack_alu.sv
module opstack_alu
  import opstack_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,   // second element
  input  logic [W-1:0] b_i,   // top element
  output logic [W-1:0] y_o
);

  always_comb begin
    case (op_i)
      OP_ADD:  y_o = a_i + b_i;
      OP_SUB:  y_o = a_i - b_i;
      OP_AND:  y_o = a_i & b_i;
      OP_OR:   y_o = a_i | b_i;
      OP_XOR:  y_o = a_i ^ b_i;
      OP_ZEQ:  y_o = {W{b_i == '0}};
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/opstack_unit.sv
module opstack_unit
  import opstack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] tos_o,
  output logic [DATA_W-1:0] nos_o,
  output logic              zero_o,
  output logic              ovf_o,
  output logic              unf_o
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 2);

  logic [CW-1:0]     cnt;
  logic              commit, ovf_evt, unf_evt, wr_en;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [DATA_W-1:0] rd_data, nos, alu_y, tos_q, tos_nxt;
  logic              zero_q, ovf_q, unf_q;

  opstack_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .step_i    (step_i),
    .op_i      (op_i),
    .cnt_o     (cnt),
    .commit_o  (commit),
    .ovf_evt_o (ovf_evt),
    .unf_evt_o (unf_evt),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .rd_addr_o (rd_addr)
  );

  opstack_ram #(.W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk     (clk),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (tos_q),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  opstack_alu #(.W(DATA_W)) u_alu (
    .op_i (op_i),
    .a_i  (nos),
    .b_i  (tos_q),
    .y_o  (alu_y)
  );

  // a stale RAM cell is never shown as the second element
  assign nos = (cnt >= CW'(2)) ? rd_data : '0;

  always_comb begin
    case (op_i)
      OP_LIT:                  tos_nxt = din_i;
      OP_DUP:                  tos_nxt = tos_q;
      OP_DROP, OP_SWAP, OP_OVER: tos_nxt = nos;
      default:                 tos_nxt = alu_y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tos_q  <= '0;
      zero_q <= 1'b1;
    end else if (commit) begin
      tos_q  <= tos_nxt;
      zero_q <= (tos_nxt == '0);
    end
  end

  // a new fault outranks an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (ovf_evt)    ovf_q <= 1'b1;
      else if (ack_i) ovf_q <= 1'b0;
      if (unf_evt)    unf_q <= 1'b1;
      else if (ack_i) unf_q <= 1'b0;
    end
  end

  assign tos_o  = tos_q;
  assign nos_o  = nos;
  assign zero_o = zero_q;
  assign ovf_o  = ovf_q;
  assign unf_o  = unf_q;

  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> ovf_o);  // R9

  AST_UNF_SET: assert property (@(posedge clk) disable iff (rst)
    unf_evt |=> unf_o);  // R10

  AST_FAULT_KEEPS_TOP: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt || unf_evt) |=> $stable(tos_o));  // R10

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !ovf_evt && !unf_evt) |=> (!ovf_o && !unf_o));  // R11

  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
    zero_o == (tos_o == '0));  // R8

  AST_IDLE_TOP: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(tos_o));  // R12

endmodule

// File: tb/test_opstack_unit.sv
`timescale 1ns/1ps
module test_opstack_unit;

  localparam int DW  = 8;
  localparam int DP  = 4;
  localparam int CAP = DP + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          step_i = 1'b0;
  logic [3:0]    op_i = 4'd0;
  logic [DW-1:0] din_i = '0;
  logic          ack_i = 1'b0;
  logic [DW-1:0] tos_o, nos_o;
  logic          zero_o, ovf_o, unf_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [DW-1:0] m [CAP];
  int            mn;
  bit            movf, munf;
  bit            last_fault;

  always #2.5 clk = ~clk;

  opstack_unit #(.DATA_W(DW), .DEPTH(DP)) i_opstack_unit (
    .clk(clk), .rst(rst), .step_i(step_i), .op_i(op_i), .din_i(din_i),
    .ack_i(ack_i), .tos_o(tos_o), .nos_o(nos_o), .zero_o(zero_o),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    case (op)
      1:            return "R2";
      2:            return "R3";
      3, 4, 5:      return "R4";
      6, 7:         return "R5";
      8, 9, 10:     return "R6";
      11:           return "R7";
      default:      return "R12";
    endcase
  endfunction

  // expected behaviour, derived from the requirements
  task automatic model(input int op, input logic [DW-1:0] d, input bit ack);
    int need;
    bit grow, live;
    logic [DW-1:0] s, t;
    live = (op >= 1) && (op <= 11);
    grow = (op == 1) || (op == 3) || (op == 5);
    need = (op == 2 || op == 3 || op == 11) ? 1 : ((op >= 4 && op <= 10) ? 2 : 0);
    if (ack) begin movf = 0; munf = 0; end
    last_fault = 0;
    if (!live) return;
    if (mn < need) begin munf = 1; last_fault = 1; return; end
    if (grow && mn == CAP) begin movf = 1; last_fault = 1; return; end
    t = (mn >= 1) ? m[mn-1] : '0;
    s = (mn >= 2) ? m[mn-2] : '0;
    case (op)
      1: begin m[mn] = d; mn++; end
      2: mn--;
      3: begin m[mn] = t; mn++; end
      4: begin m[mn-1] = s; m[mn-2] = t; end
      5: begin m[mn] = s; mn++; end
      6: begin m[mn-2] = s + t; mn--; end
      7: begin m[mn-2] = s - t; mn--; end
      8: begin m[mn-2] = s & t; mn--; end
      9: begin m[mn-2] = s | t; mn--; end
      10: begin m[mn-2] = s ^ t; mn--; end
      11: m[mn-1] = (t == '0) ? '1 : '0;
      default: ;
    endcase
  endtask

  task automatic compare(input string tag);
    logic [DW-1:0] et, en;
    et = (mn >= 1) ? m[mn-1] : '0;
    en = (mn >= 2) ? m[mn-2] : '0;
    chk(tag, "tos", 32'(tos_o), 32'(et));
    chk(tag, "nos", 32'(nos_o), 32'(en));
    chk("R8", "zero", 32'(zero_o), 32'(et == '0));
    chk(tag, "ovf", 32'(ovf_o), 32'(movf));
    chk(tag, "unf", 32'(unf_o), 32'(munf));
  endtask

  task automatic do_step(input int op, input logic [DW-1:0] d, input bit ack);
    @(negedge clk);
    step_i = 1'b1; op_i = 4'(op); din_i = d; ack_i = ack;
    @(negedge clk);
    step_i = 1'b0; ack_i = 1'b0;
    model(op, d, ack);
  endtask

  task automatic do_idle(input int op, input logic [DW-1:0] d, input bit ack);
    @(negedge clk);
    step_i = 1'b0; op_i = 4'(op); din_i = d; ack_i = ack;
    @(negedge clk);
    ack_i = 1'b0;
    if (ack) begin movf = 0; munf = 0; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; step_i = 1'b0; ack_i = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mn = 0; movf = 0; munf = 0;
  endtask

  task automatic drain(input string tag);
    while (mn > 0) begin
      do_step(2, '0, 0);
      compare(tag);
    end
  endtask

  initial begin
    mn = 0; movf = 0; munf = 0;
    do_reset();
    compare("R1");

    // every code at every fill level
    for (int op = 0; op < 16; op++) begin
      for (int d = 0; d <= CAP; d++) begin
        do_reset();
        for (int k = 0; k < d; k++)
          do_step(1, (k == 1) ? 8'h00 : 8'(op * 16 + k * 37 + 3), 0);
        do_idle(op, 8'h5A, 0);
        compare("R12");
        do_step(op, 8'hA5 ^ 8'(op), 0);
        if (last_fault) compare((op == 1 || op == 3 || op == 5) && d == CAP ? "R9" : "R10");
        else            compare(req_of(op));
        drain(req_of(op));
      end
    end

    // ALU codes over a grid of operand pairs
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int op = 6; op <= 11; op++) begin
          do_reset();
          do_step(1, 8'(a * 17), 0);
          do_step(1, 8'(b * 17) ^ 8'(a), 0);
          do_step(op, '0, 0);
          compare(req_of(op));
        end
      end
    end

    // fault and acknowledge in the same cycle
    do_reset();
    for (int k = 0; k < CAP; k++) do_step(1, 8'(k + 1), 0);
    do_step(1, 8'hEE, 1);
    compare("R11");
    chk("R11", "ovf_after_ack_and_fault", 32'(ovf_o), 32'd1);
    do_idle(0, '0, 1);
    compare("R11");
    chk("R11", "ovf_after_ack", 32'(ovf_o), 32'd0);
    do_reset();
    do_step(2, '0, 1);
    compare("R11");
    chk("R11", "unf_after_ack_and_fault", 32'(unf_o), 32'd1);
    do_idle(0, '0, 1);
    chk("R11", "unf_after_ack", 32'(unf_o), 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule